// File: doc/BRIEF.md
# Three-Line Handshake Byte Link

This block is the device end of a byte-wide link to a host processor. Three active-low handshake lines carry the flow control. The host drives transfer-in-progress and transfer-acknowledge, and the device drives transfer-request. Data crosses a shared shift register. When the host is writing, the host side places a byte in that register and the block captures it into a receive buffer. When the device is sending, the block places the next byte of a transmit buffer into the register for the host to read.

The host decoding logic gives the block a strobe each time the host writes its port register. The block reacts only to those strobes. Within a transfer, a byte moves only when the in-progress/acknowledge pair differs from the pair seen at the previous strobe. A direction input selects whether the host writes or reads. Each step schedules a shift-register interrupt, which fires a fixed number of clock cycles later. When the host ends a write transfer that carried data, the block pulses a packet-done flag with the byte count. An upstream agent fills the transmit buffer and loads its length.

Between transfers the block answers a toggle of acknowledge by copying its level onto request. This is the sync step. Whenever the link is idle and unread bytes are waiting, the block holds request low.

Top module: `shake_link`

## Requirements
- R1: After reset, req_n is 1, sr_irq and pkt_done are 0, dev_sr is 0, both buffer positions and the pending length are zero, and the stored previous levels of in-progress and acknowledge are both 1.
- R2: On a port write with host_tip_n=0 and shift_out=1, host_sr is stored at the next receive position only if {host_tip_n,host_ack_n} differs from the pair at the previous port write. The captured bytes read back in order at rx_addr 0, 1, 2 and so on.
- R3: The receive buffer holds DEPTH bytes. Bytes offered when it is full are dropped, so pkt_len never exceeds DEPTH.
- R4: On a port write with host_tip_n=0, shift_out=0, a changed pair and unread bytes pending, the next transmit byte appears on dev_sr in the following cycle. When that byte is the last one, req_n goes to 1. dev_sr changes at no other time.
- R5: On a port write with host_tip_n=1 when the previous in-progress level was also 1, a change in acknowledge copies the new host_ack_n level onto req_n and schedules an interrupt.
- R6: A port write that takes in-progress from 0 to 1 always schedules an interrupt. If bytes were captured, pkt_done pulses for one cycle with pkt_len equal to the capture count, and the count then restarts at zero. If no bytes were captured, there is no pulse.
- R7: On an idle, non-sync port write, req_n is driven to 0 if unread transmit bytes remain. A transmit load of a nonzero length while idle also drives req_n to 0.
- R8: sr_irq is a one-cycle pulse exactly DELAY_CYC clock edges after the edge that scheduled it. Scheduling again before it fires restarts the delay.
- R9: tx_load sets the pending length to tx_len, returns the read position to zero and schedules an interrupt. A tx_load in the same cycle as port_wr is ignored.
- R10: In device-to-host mode with no bytes pending, a port write changes neither dev_sr nor schedules an interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| port_wr | input | 1 | One-cycle strobe: host wrote the handshake port |
| host_tip_n | input | 1 | Transfer-in-progress level at that write, active low |
| host_ack_n | input | 1 | Transfer-acknowledge level at that write, active low |
| shift_out | input | 1 | Direction: 1 host writes to device, 0 device sends to host |
| host_sr | input | 8 | Shift-register byte written by the host |
| req_n | output | 1 | Transfer-request to the host, active low |
| dev_sr | output | 8 | Shift-register byte presented to the host |
| sr_irq | output | 1 | Delayed shift-register interrupt pulse |
| pkt_done | output | 1 | One-cycle pulse: host packet complete |
| pkt_len | output | $clog2(DEPTH+1) | Byte count of the completed packet |
| rx_addr | input | $clog2(DEPTH) | Receive buffer read address |
| rx_data | output | 8 | Receive buffer byte at rx_addr |
| tx_we | input | 1 | Transmit buffer write enable |
| tx_waddr | input | $clog2(DEPTH) | Transmit buffer write address |
| tx_wdata | input | 8 | Transmit buffer write byte |
| tx_load | input | 1 | Start a new device-to-host packet |
| tx_len | input | $clog2(DEPTH+1) | Length of that packet, at most DEPTH |

## Verification
A wrong receive or read position shows up one cycle after the next port write, as a wrong dev_sr byte or a wrong pkt_len. A wrong remembered handshake pair shows up the same way: a byte is skipped or moved twice, or a sync step is mistaken for the end of a transfer, which changes req_n and the packet pulse. Timer faults appear only DELAY_CYC cycles later, as an interrupt that is early, late, doubled or missing. The reference model therefore compares every output on every cycle rather than only at packet boundaries.

// File: rtl/shake_link_pkg.sv
package shake_link_pkg;

  // One port strobe or load yields at most one of these steps.
  typedef enum logic [2:0] {
    EV_NONE,
    EV_CAPTURE,
    EV_SEND,
    EV_SYNC,
    EV_END,
    EV_IDLE,
    EV_LOAD
  } step_e;

endpackage

// File: rtl/shake_link_buf.sv
module shake_link_buf #(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (we && (waddr == AW'(g))) begin
        mem[g] <= wdata;
      end
    end
  end

  always_comb begin
    if (32'(raddr) < DEPTH) rdata = mem[raddr];
    else                    rdata = 8'h00;
  end

endmodule

// File: rtl/shake_link_delay.sv
module shake_link_delay #(
  parameter int DELAY_CYC = 4000,
  localparam int CNTW = $clog2(DELAY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sched,
  output logic irq
);

  logic [CNTW-1:0] cnt_q, cnt_d;
  logic            irq_d;

  always_comb begin
    irq_d = (cnt_q == CNTW'(1)) && !sched;
    cnt_d = cnt_q;
    if (sched)                   cnt_d = CNTW'(DELAY_CYC);
    else if (cnt_q != '0)        cnt_d = cnt_q - CNTW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq   <= irq_d;
    end
  end

endmodule

// File: rtl/shake_link_ctl.sv
module shake_link_ctl
  import shake_link_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_wr,
  input  logic          tip_n,
  input  logic          ack_n,
  input  logic          shift_out,
  input  logic          tx_load,
  input  logic [CW-1:0] tx_len,
  input  logic [7:0]    tx_rdata,
  output logic [AW-1:0] tx_raddr,
  output logic          rx_we,
  output logic [AW-1:0] rx_waddr,
  output logic          sched,
  output logic          req_n,
  output logic [7:0]    dev_sr,
  output logic          pkt_done,
  output logic [CW-1:0] pkt_len
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  step_e         step;
  logic          changed, upd;
  logic          last_tip_q, last_tip_d, last_ack_q, last_ack_d;
  logic          req_d, pkt_done_d;
  logic [7:0]    dev_sr_d;
  logic [CW-1:0] wr_q, wr_d, rd_q, rd_d, pend_q, pend_d, pkt_len_d;

  // step selection
  always_comb begin
    changed = ({tip_n, ack_n} != {last_tip_q, last_ack_q});
    step    = EV_NONE;
    if (port_wr) begin
      if (!tip_n) begin
        if (shift_out) begin
          if (changed && (wr_q < FULL)) step = EV_CAPTURE;
        end else if (changed && (rd_q < pend_q)) begin
          step = EV_SEND;
        end
      end else if (last_tip_q && (ack_n != last_ack_q)) begin
        step = EV_SYNC;
      end else if (!last_tip_q) begin
        step = EV_END;
      end else begin
        step = EV_IDLE;
      end
    end else if (tx_load) begin
      step = EV_LOAD;
    end
  end

  // next state
  always_comb begin
    wr_d       = wr_q;
    rd_d       = rd_q;
    pend_d     = pend_q;
    req_d      = req_n;
    dev_sr_d   = dev_sr;
    pkt_done_d = 1'b0;
    pkt_len_d  = pkt_len;
    sched      = 1'b0;
    rx_we      = 1'b0;
    last_tip_d = port_wr ? tip_n : last_tip_q;
    last_ack_d = port_wr ? ack_n : last_ack_q;
    case (step)
      EV_CAPTURE: begin
        rx_we = 1'b1;
        wr_d  = wr_q + CW'(1);
        sched = 1'b1;
      end
      EV_SEND: begin
        dev_sr_d = tx_rdata;
        rd_d     = rd_q + CW'(1);
        if ((rd_q + CW'(1)) >= pend_q) req_d = 1'b1;
        sched    = 1'b1;
      end
      EV_SYNC: begin
        req_d = ack_n;
        sched = 1'b1;
      end
      EV_END: begin
        sched = 1'b1;
        if (wr_q != '0) begin
          pkt_done_d = 1'b1;
          pkt_len_d  = wr_q;
          wr_d       = '0;
        end
        if (rd_q < pend_q) req_d = 1'b0;
      end
      EV_IDLE: begin
        if (rd_q < pend_q) req_d = 1'b0;
      end
      EV_LOAD: begin
        rd_d   = '0;
        pend_d = tx_len;
        if (last_tip_q && (tx_len != '0)) req_d = 1'b0;
        sched  = 1'b1;
      end
      default: ;
    endcase
  end

  assign upd      = port_wr | tx_load;
  assign tx_raddr = rd_q[AW-1:0];
  assign rx_waddr = wr_q[AW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_tip_q <= 1'b1;
      last_ack_q <= 1'b1;
      req_n      <= 1'b1;
      dev_sr     <= 8'h00;
      wr_q       <= '0;
      rd_q       <= '0;
      pend_q     <= '0;
      pkt_len    <= '0;
    end else if (upd) begin
      last_tip_q <= last_tip_d;
      last_ack_q <= last_ack_d;
      req_n      <= req_d;
      dev_sr     <= dev_sr_d;
      wr_q       <= wr_d;
      rd_q       <= rd_d;
      pend_q     <= pend_d;
      pkt_len    <= pkt_len_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pkt_done <= 1'b0;
    else        pkt_done <= pkt_done_d;
  end

endmodule

// File: rtl/shake_link.sv
module shake_link #(
  parameter int DEPTH = 16,
  parameter int DELAY_CYC = 4000,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          port_wr,
  input  logic          host_tip_n,
  input  logic          host_ack_n,
  input  logic          shift_out,
  input  logic [7:0]    host_sr,
  output logic          req_n,
  output logic [7:0]    dev_sr,
  output logic          sr_irq,
  output logic          pkt_done,
  output logic [CW-1:0] pkt_len,
  input  logic [AW-1:0] rx_addr,
  output logic [7:0]    rx_data,
  input  logic          tx_we,
  input  logic [AW-1:0] tx_waddr,
  input  logic [7:0]    tx_wdata,
  input  logic          tx_load,
  input  logic [CW-1:0] tx_len
);

  logic [1:0]    rst_sync_q;
  logic          rst_core_n;
  logic          sched, rx_we;
  logic [AW-1:0] rx_waddr, tx_raddr;
  logic [7:0]    tx_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  shake_link_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rst_n(rst_core_n), .port_wr(port_wr),
    .tip_n(host_tip_n), .ack_n(host_ack_n), .shift_out(shift_out),
    .tx_load(tx_load), .tx_len(tx_len), .tx_rdata(tx_rdata),
    .tx_raddr(tx_raddr), .rx_we(rx_we), .rx_waddr(rx_waddr),
    .sched(sched), .req_n(req_n), .dev_sr(dev_sr),
    .pkt_done(pkt_done), .pkt_len(pkt_len)
  );

  shake_link_buf #(.DEPTH(DEPTH)) u_rxbuf (
    .clk(clk), .we(rx_we), .waddr(rx_waddr), .wdata(host_sr),
    .raddr(rx_addr), .rdata(rx_data)
  );

  shake_link_buf #(.DEPTH(DEPTH)) u_txbuf (
    .clk(clk), .we(tx_we), .waddr(tx_waddr), .wdata(tx_wdata),
    .raddr(tx_raddr), .rdata(tx_rdata)
  );

  shake_link_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
    .clk(clk), .rst_n(rst_core_n), .sched(sched), .irq(sr_irq)
  );

endmodule

// File: rtl/shake_link_chk.sv
module shake_link_chk #(
  parameter int DEPTH = 16,
  parameter int DELAY_CYC = 4000,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int SW = $clog2(DELAY_CYC + 2) + 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sched,
  input logic          port_wr,
  input logic          tx_load,
  input logic          sr_irq,
  input logic          pkt_done,
  input logic [CW-1:0] pkt_len,
  input logic          req_n,
  input logic [7:0]    dev_sr
);

  localparam logic [SW-1:0] LIM = SW'(DELAY_CYC + 1);

  logic [SW-1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              since_q <= '0;
    else if (sched)                          since_q <= SW'(1);
    else if (sr_irq)                         since_q <= '0;
    else if ((since_q != '0) && (since_q < LIM)) since_q <= since_q + SW'(1);
  end

  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |=> !sr_irq);

  assert_irq_delay_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_irq |-> (since_q == LIM));

  assert_pkt_nonzero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len != '0));

  assert_pkt_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(sched));

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> (pkt_len <= CW'(DEPTH)));

  assert_sr_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !port_wr |=> $stable(dev_sr));

  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!port_wr && !tx_load) |=> $stable(req_n));

endmodule

bind shake_link shake_link_chk #(.DEPTH(DEPTH), .DELAY_CYC(DELAY_CYC)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .sched(sched), .port_wr(port_wr),
  .tx_load(tx_load), .sr_irq(sr_irq), .pkt_done(pkt_done),
  .pkt_len(pkt_len), .req_n(req_n), .dev_sr(dev_sr)
);

// File: tb/shake_link_bench.sv
`timescale 1ns/1ps
module shake_link_bench;

  localparam int DEPTH = 16;
  localparam int D     = 6;
  localparam int AW    = $clog2(DEPTH);
  localparam int CW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n, port_wr, host_tip_n, host_ack_n, shift_out;
  logic [7:0]    host_sr, dev_sr, rx_data, tx_wdata;
  logic          req_n, sr_irq, pkt_done, tx_we, tx_load;
  logic [CW-1:0] pkt_len, tx_len;
  logic [AW-1:0] rx_addr, tx_waddr;

  always #2.5 clk = ~clk;

  shake_link #(.DEPTH(DEPTH), .DELAY_CYC(D)) u_shake_link (
    .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .host_tip_n(host_tip_n),
    .host_ack_n(host_ack_n), .shift_out(shift_out), .host_sr(host_sr),
    .req_n(req_n), .dev_sr(dev_sr), .sr_irq(sr_irq), .pkt_done(pkt_done),
    .pkt_len(pkt_len), .rx_addr(rx_addr), .rx_data(rx_data), .tx_we(tx_we),
    .tx_waddr(tx_waddr), .tx_wdata(tx_wdata), .tx_load(tx_load), .tx_len(tx_len)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_lt, m_la, m_req, m_sr, m_wr, m_rd, m_pend, m_tmr, m_irq, m_pd, m_plen;
  logic [7:0] txa [DEPTH];
  logic [7:0] rxq [$];
  logic [7:0] last_pkt [$];

  always @(posedge clk) begin
    bit s, chg;
    if (!rst_n) begin
      m_lt = 1; m_la = 1; m_req = 1; m_sr = 0; m_wr = 0; m_rd = 0;
      m_pend = 0; m_tmr = 0; m_irq = 0; m_pd = 0; m_plen = 0;
      rxq = {};
    end else begin
      s = 0;
      m_pd = 0;
      if (port_wr) begin
        chg = (int'(host_tip_n) != m_lt) || (int'(host_ack_n) != m_la);
        if (!host_tip_n) begin
          if (shift_out) begin
            if (chg && m_wr < DEPTH) begin rxq.push_back(host_sr); m_wr++; s = 1; end
          end else if (chg && m_rd < m_pend) begin
            m_sr = txa[m_rd]; m_rd++;
            if (m_rd >= m_pend) m_req = 1;
            s = 1;
          end
        end else if (m_lt == 1 && int'(host_ack_n) != m_la) begin
          m_req = host_ack_n; s = 1;
        end else begin
          if (m_lt == 0) begin
            s = 1;
            if (m_wr > 0) begin
              m_pd = 1; m_plen = m_wr; last_pkt = rxq; rxq = {}; m_wr = 0;
            end
          end
          if (m_rd < m_pend) m_req = 0;
        end
        m_lt = host_tip_n; m_la = host_ack_n;
      end else if (tx_load) begin
        m_rd = 0; m_pend = tx_len;
        if (m_lt == 1 && tx_len != 0) m_req = 0;
        s = 1;
      end
      if (tx_we) txa[tx_waddr] = tx_wdata;
      m_irq = (m_tmr == 1 && !s) ? 1 : 0;
      if (s) m_tmr = D;
      else if (m_tmr > 0) m_tmr--;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R5 req_n vs model", req_n, m_req);
      chk("R4 dev_sr vs model", dev_sr, m_sr);
      chk("R8 sr_irq vs model", sr_irq, m_irq);
      chk("R6 pkt_done vs model", pkt_done, m_pd);
      if (m_pd) chk("R6 pkt_len vs model", pkt_len, m_plen);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic pwr(input logic t, input logic a);
    host_tip_n = t; host_ack_n = a; port_wr = 1'b1;
    @(negedge clk);
    port_wr = 1'b0;
  endtask

  task automatic settle();
    repeat (D + 3) @(negedge clk);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!sr_irq && n < 50) begin @(negedge clk); n++; end
  endtask

  task automatic rx_read(input int a, output logic [7:0] v);
    rx_addr = AW'(a);
    #1 v = rx_data;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    logic [7:0] v;
    rst_n = 1'b0; port_wr = 1'b0; host_tip_n = 1'b1; host_ack_n = 1'b1;
    shift_out = 1'b1; host_sr = 8'h00; rx_addr = '0; tx_we = 1'b0;
    tx_waddr = '0; tx_wdata = 8'h00; tx_load = 1'b0; tx_len = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 req_n after reset", req_n, 1);
    chk("R1 sr_irq after reset", sr_irq, 0);
    chk("R1 pkt_done after reset", pkt_done, 0);
    chk("R1 dev_sr after reset", dev_sr, 0);

    // host-to-device packet of three bytes, one repeated pair ignored
    shift_out = 1'b1;
    host_sr = 8'hA1; pwr(0, 1);
    wait_irq(n);
    chk("R8 irq delay after capture", n, D);
    settle();
    host_sr = 8'hB2; pwr(0, 0);
    host_sr = 8'hC3; pwr(0, 1);
    host_sr = 8'hEE; pwr(0, 1);
    settle();
    pwr(1, 1);
    chk("R6 pkt_done on end", pkt_done, 1);
    chk("R6 pkt_len on end", pkt_len, 3);
    rx_read(0, v); chk("R2 rx byte 0", v, 8'hA1);
    rx_read(1, v); chk("R2 rx byte 1", v, 8'hB2);
    rx_read(2, v); chk("R2 rx byte 2", v, 8'hC3);
    settle();

    // idle sync and restart of the delay
    pwr(1, 0);
    chk("R5 req follows ack low", req_n, 0);
    repeat (2) @(negedge clk);
    pwr(1, 1);
    chk("R5 req follows ack high", req_n, 1);
    wait_irq(n);
    chk("R8 delay restarted", n, D);
    settle();

    // overflow: 18 bytes offered to a 16-byte buffer
    for (int i = 0; i < 18; i++) begin
      host_sr = 8'(i + 16);
      pwr(0, logic'(i % 2));
    end
    pwr(1, 1);
    chk("R3 pkt_len clipped", pkt_len, DEPTH);
    rx_read(15, v); chk("R3 last kept byte", v, 8'd31);
    settle();

    // device-to-host packet of three bytes
    shift_out = 1'b0;
    for (int i = 0; i < 3; i++) begin
      tx_we = 1'b1; tx_waddr = AW'(i); tx_wdata = 8'(8'h50 + i);
      @(negedge clk);
    end
    tx_we = 1'b0;
    tx_len = CW'(3); tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    chk("R9 load asserts request", req_n, 0);
    settle();
    pwr(0, 1);
    chk("R4 first byte", dev_sr, 8'h50);
    chk("R7 request held while pending", req_n, 0);
    pwr(0, 0);
    chk("R4 second byte", dev_sr, 8'h51);
    pwr(0, 0);
    chk("R4 unchanged pair holds byte", dev_sr, 8'h51);
    pwr(0, 1);
    chk("R4 last byte", dev_sr, 8'h52);
    chk("R4 request released after last", req_n, 1);
    settle();
    pwr(0, 0);
    wait_irq(n);
    chk("R10 no irq when nothing pending", n, 50);
    chk("R10 dev_sr unchanged", dev_sr, 8'h52);
    pwr(1, 1);
    chk("R6 no pulse without capture", pkt_done, 0);
    wait_irq(n);
    chk("R6 irq on every end", n, D);
    settle();

    // partially read packet leaves request asserted at end
    tx_len = CW'(2); tx_load = 1'b1;
    @(negedge clk);
    tx_load = 1'b0;
    settle();
    pwr(0, 1);
    chk("R9 read index restarted", dev_sr, 8'h50);
    settle();
    pwr(1, 1);
    chk("R7 unread bytes assert request", req_n, 0);
    settle();
    pwr(0, 0);
    pwr(1, 1);
    chk("R7 drained request high", req_n, 1);
    settle();

    // load colliding with a port write is dropped
    tx_len = CW'(2); tx_load = 1'b1;
    pwr(1, 1);
    tx_load = 1'b0;
    chk("R9 colliding load ignored (req)", req_n, 1);
    pwr(0, 0);
    chk("R9 colliding load ignored (data)", dev_sr, 8'h51);
    settle();

    $display("  CHECKS %0d ERRORS %0d", checks, fails);
    $finish;
  end

endmodule